// File: doc/BRIEF.md
# Mesochronous Edge-Select Synchronizer

This block moves a stream of data words from a sending clock domain into a receiving one when both clocks share a frequency but sit at an unknown, fixed phase offset. The sender forwards its own clock beside the data. The receiver uses that clock as a write strobe and stores each word into a small rotating buffer. No two-flop synchronizer sits in the data path. Instead, the receiver decides once which edge of its own clock is safe for reading that buffer: the rising edge or the falling edge.

The decision comes from a short window that opens at each strobe rising edge and closes when a delayed copy of the strobe rises. The delay is supplied from outside the block. After reset, the receiver spends a training interval sampling that window on its own rising edges. If any sample lands inside the window, its rising edge is too close to the strobe, so reads switch to the falling edge. The choice is then frozen. Data taken on either edge is re-registered on the local rising edge, and a valid flag marks the stream as usable.

Top module: `meso_edge_sync`

## Requirements
- R1: While reset is low, and during training afterwards, `rx_valid` is 0 and `rx_data` is all zeros.
- R2: `rx_valid` first reads 1 after the (TRAIN_CYC+1)-th local rising edge that follows reset release, and it then stays 1 until reset.
- R3: The window is high when `strobe` is 1 and `strobe_dly` is 0. If any local rising edge during training samples the window high, words are read on the local falling edge. Otherwise they are read on the local rising edge.
- R4: The read edge chosen at the end of training does not change until the next reset.
- R5: Each rising edge of `strobe` outside reset writes `tx_data` into one buffer slot. The slot index advances by one per strobe edge and wraps from DEPTH-1 to 0.
- R6: Once `rx_valid` is 1, each local cycle presents the word that follows the previous one in send order, with none lost or repeated, at every phase offset from 0 to 360 degrees.
- R7: Within one run after reset, the distance between the word being sent and `rx_data`, sampled at the local falling edge, is constant and lies between 1 and 3 words.
- R8: `rx_data` changes only at local rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_local | input | 1 | Receiving-domain clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both domains |
| strobe | input | 1 | Clock forwarded from the sender; writes the buffer on its rising edge |
| strobe_dly | input | 1 | Copy of `strobe` delayed by an external delay line |
| tx_data | input | W | Word from the sender, stable around each strobe rising edge |
| rx_data | output | W | Received word, aligned to the local rising edge |
| rx_valid | output | 1 | High once training has completed |

## Verification
The bench builds the block with DEPTH=2, TRAIN_CYC=6 and W=16, using a delay of 1 ns on the strobe copy. The forwarded clock is swept through 24 phase offsets in 333 ps steps. The top three offsets put the local rising edge inside the window, so both read paths, rising and falling, carry real traffic. A 16-bit word counter gives each word a distinct value, so a lost or repeated word appears directly as a broken sequence or a change in the lag.

// File: rtl/meso_sync_pkg.sv
// Shared types for the mesochronous edge-select synchronizer.
// Assumes: nothing beyond IEEE 1800-2017.
package meso_sync_pkg;

    // Which local clock edge reads the data buffer.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } cap_edge_e;

endpackage

// File: rtl/meso_window.sv
// Selection-window generator: high from the strobe rising edge until the
// delayed strobe rises. Assumes the external delay is shorter than half a
// clock period, so the window never overlaps the falling-edge read point.
module meso_window (
    input  logic strobe,
    input  logic strobe_dly,
    output logic window
);

    // Window is open while the strobe has risen but its delayed copy has not.
    always_comb window = strobe & ~strobe_dly;

endmodule

// File: rtl/meso_select.sv
// Selection-signal generator: samples the window on local rising edges for
// TRAIN_CYC cycles after reset, then freezes the read-edge choice.
// Assumes clocks of equal frequency and a phase offset fixed after reset.
module meso_select
    import meso_sync_pkg::*;
#(
    parameter int TRAIN_CYC = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      window,
    output cap_edge_e sel,
    output logic      trained
);

    localparam int CW = $clog2(TRAIN_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TRAIN_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          hit_q;

    // Count training cycles, accumulate window hits, and latch the edge choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            hit_q   <= 1'b0;
            sel     <= EDGE_RISE;
            trained <= 1'b0;
        end else if (!trained) begin
            cnt_q <= cnt_q + CW'(1);
            hit_q <= hit_q | window;
            if (cnt_q == CNT_LAST) begin
                trained <= 1'b1;
                sel     <= (hit_q | window) ? EDGE_FALL : EDGE_RISE;
            end
        end
    end

endmodule

// File: rtl/meso_buffer.sv
// Data buffer on the sender side: each strobe rising edge writes one slot,
// rotating through DEPTH slots, so a slot holds its word for DEPTH periods.
// Assumes tx_data is stable around the strobe rising edge.
module meso_buffer #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic                       strobe,
    input  logic                       rst_n,
    input  logic [W-1:0]               din,
    output logic [DEPTH-1:0][W-1:0]    slots,
    output logic [$clog2(DEPTH)-1:0]   wp
);

    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    // Store the incoming word and advance the write pointer with wrap.
    always_ff @(posedge strobe) begin
        if (!rst_n) begin
            slots <= '0;
            wp    <= '0;
        end else begin
            slots[wp] <= din;
            wp        <= (wp == LAST) ? '0 : wp + PW'(1);
        end
    end

endmodule

// File: rtl/meso_capture.sv
// Reads the buffer on one local clock edge picked by FALLING. Before training
// ends it tracks the most recently written slot; afterwards it steps its own
// read pointer and stops looking at the write pointer.
// Assumes the edge in use is the safe one when its output is consumed.
module meso_capture #(
    parameter int W       = 16,
    parameter int DEPTH   = 2,
    parameter bit FALLING = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     trained,
    input  logic [DEPTH-1:0][W-1:0]  slots,
    input  logic [$clog2(DEPTH)-1:0] wp,
    output logic [W-1:0]             word
);

    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] rp_q;
    logic [PW-1:0] idx;
    logic [PW-1:0] rp_nxt;

    // Pick the slot: newest written during training, own pointer afterwards.
    always_comb begin
        if (trained) idx = rp_q;
        else         idx = (wp == '0) ? LAST : wp - PW'(1);
        rp_nxt = (idx == LAST) ? '0 : idx + PW'(1);
    end

    if (FALLING) begin : g_fall
        // Read the chosen slot on the local falling edge.
        always_ff @(negedge clk) begin
            if (!rst_n) begin
                rp_q <= '0;
                word <= '0;
            end else begin
                rp_q <= rp_nxt;
                word <= slots[idx];
            end
        end
    end else begin : g_rise
        // Read the chosen slot on the local rising edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rp_q <= '0;
                word <= '0;
            end else begin
                rp_q <= rp_nxt;
                word <= slots[idx];
            end
        end
    end

endmodule

// File: rtl/meso_edge_sync.sv
// Mesochronous edge-select synchronizer top. Writes words into a rotating
// buffer on the forwarded strobe, chooses a safe local edge once after reset,
// and re-registers the result on the local rising edge.
// Assumes equal frequencies, a fixed phase, TRAIN_CYC >= 4 and DEPTH >= 2.
module meso_edge_sync
    import meso_sync_pkg::*;
#(
    parameter int W         = 16,
    parameter int DEPTH     = 2,
    parameter int TRAIN_CYC = 6
) (
    input  logic         clk_local,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic         strobe_dly,
    input  logic [W-1:0] tx_data,
    output logic [W-1:0] rx_data,
    output logic         rx_valid
);

    localparam int PW = $clog2(DEPTH);

    logic                    window;
    cap_edge_e               sel;
    logic                    trained;
    logic [DEPTH-1:0][W-1:0] slots;
    logic [PW-1:0]           wp;
    logic [1:0][W-1:0]       cap_word;

    meso_window u_win (
        .strobe     (strobe),
        .strobe_dly (strobe_dly),
        .window     (window)
    );

    meso_select #(.TRAIN_CYC(TRAIN_CYC)) u_sel (
        .clk     (clk_local),
        .rst_n   (rst_n),
        .window  (window),
        .sel     (sel),
        .trained (trained)
    );

    meso_buffer #(.W(W), .DEPTH(DEPTH)) u_buf (
        .strobe (strobe),
        .rst_n  (rst_n),
        .din    (tx_data),
        .slots  (slots),
        .wp     (wp)
    );

    for (genvar e = 0; e < 2; e++) begin : g_cap
        meso_capture #(.W(W), .DEPTH(DEPTH), .FALLING(e == 1)) u_cap (
            .clk     (clk_local),
            .rst_n   (rst_n),
            .trained (trained),
            .slots   (slots),
            .wp      (wp),
            .word    (cap_word[e])
        );
    end

    // Align the word from the chosen edge to the local rising edge.
    always_ff @(posedge clk_local) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= trained;
            rx_data  <= trained ? cap_word[sel == EDGE_FALL] : '0;
        end
    end

endmodule

// File: rtl/meso_edge_sync_chk.sv
// Assertion checker for meso_edge_sync, attached with bind below.
// Assumes the same DEPTH as the design it watches.
module meso_edge_sync_chk #(
    parameter int DEPTH = 2
) (
    input logic                     clk_local,
    input logic                     strobe,
    input logic                     rst_n,
    input logic                     window,
    input logic                     trained,
    input logic                     sel,
    input logic                     rx_valid,
    input logic [$clog2(DEPTH)-1:0] wp
);

    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic seen_q;

    // Remember whether any training sample found the window open.
    always_ff @(posedge clk_local) begin
        if (!rst_n)                  seen_q <= 1'b0;
        else if (!trained && window) seen_q <= 1'b1;
    end

    a_r1_no_valid_in_training: assert property (@(posedge clk_local) disable iff (!rst_n)
        !trained |-> !rx_valid);

    a_r2_valid_after_training: assert property (@(posedge clk_local) disable iff (!rst_n)
        $rose(trained) |=> rx_valid);

    a_r2_valid_sticky: assert property (@(posedge clk_local) disable iff (!rst_n)
        rx_valid |=> rx_valid);

    a_r3_edge_matches_window: assert property (@(posedge clk_local) disable iff (!rst_n)
        $rose(trained) |-> (sel == seen_q));

    a_r4_edge_frozen: assert property (@(posedge clk_local) disable iff (!rst_n)
        trained |=> (trained && $stable(sel)));

    a_r5_slot_rotation: assert property (@(posedge strobe) disable iff (!rst_n)
        1'b1 |=> (wp == (($past(wp) == LAST) ? '0 : $past(wp) + PW'(1))));

endmodule

bind meso_edge_sync meso_edge_sync_chk #(.DEPTH(DEPTH)) u_chk (
    .clk_local (clk_local),
    .strobe    (strobe),
    .rst_n     (rst_n),
    .window    (window),
    .trained   (trained),
    .sel       (sel),
    .rx_valid  (rx_valid),
    .wp        (wp)
);

// File: tb/sim_meso_edge_sync.sv
// Bench: sweeps the forwarded clock phase and checks the received stream
// against a behavioural model (expected word = sent word minus a fixed lag).
`timescale 1ns/1ps
module sim_meso_edge_sync;

    localparam int    W         = 16;
    localparam int    DEPTH     = 2;
    localparam int    TRAIN_CYC = 6;
    localparam int    STEPS     = 24;
    localparam real   DLY_NS    = 1.0;
    localparam real   PER_NS    = 8.0;

    logic         clk_local = 1'b0;
    logic         rst_n     = 1'b0;
    logic         strobe    = 1'b0;
    logic         strobe_dly = 1'b0;
    logic [W-1:0] tx_data   = '0;
    logic [W-1:0] rx_data;
    logic         rx_valid;

    real ph_ns = 0.1;
    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    meso_edge_sync #(.W(W), .DEPTH(DEPTH), .TRAIN_CYC(TRAIN_CYC)) u0 (
        .clk_local  (clk_local),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .strobe_dly (strobe_dly),
        .tx_data    (tx_data),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid)
    );

    // 125 MHz local clock.
    initial forever #(PER_NS / 2.0) clk_local = ~clk_local;

    // Forwarded clock at the swept phase, and its delayed copy.
    always @(clk_local) strobe <= #(ph_ns) clk_local;
    always @(strobe) strobe_dly <= #(DLY_NS) strobe;

    // Sender: a new word each cycle, changed away from the strobe rising edge.
    always @(negedge strobe) tx_data <= tx_data + W'(1);

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (phase %0.3f ns)", req, act, exp, ph_ns);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(150000 * PER_NS);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] lag0;
        logic [W-1:0] prev;
        logic [W-1:0] lag_now;
        for (int i = 0; i < STEPS; i++) begin
            rst_n = 1'b0;
            ph_ns = 0.1 + 0.333 * i;
            repeat (4) @(posedge clk_local);
            @(negedge clk_local);
            // R1: reset state at the ports
            chk(rx_valid == 1'b0, "R1 valid in reset", W'(rx_valid), '0);
            chk(rx_data == '0, "R1 data in reset", rx_data, '0);
            rst_n = 1'b1;
            for (int n = 1; n <= TRAIN_CYC + 1; n++) begin
                @(posedge clk_local);
                @(negedge clk_local);
                if (n <= TRAIN_CYC) begin
                    chk(rx_valid == 1'b0, "R1 valid in training", W'(rx_valid), '0);
                    chk(rx_data == '0, "R1 data in training", rx_data, '0);
                end else begin
                    chk(rx_valid == 1'b1, "R2 valid after training", W'(rx_valid), W'(1));
                end
            end
            lag0 = tx_data - rx_data;
            chk(lag0 >= W'(1) && lag0 <= W'(3), "R7 lag range", lag0, W'(2));
            prev = rx_data;
            for (int c = 0; c < 30; c++) begin
                #(PER_NS / 2.0 - 0.5);
                // R8: output held until the next rising edge
                chk(rx_data == prev, "R8 data stable between rising edges", rx_data, prev);
                @(posedge clk_local);
                @(negedge clk_local);
                chk(rx_valid == 1'b1, "R2 valid stays high", W'(rx_valid), W'(1));
                if (ph_ns > PER_NS - DLY_NS)
                    chk(rx_data == prev + W'(1), "R6/R3 sequence on falling-edge path", rx_data, prev + W'(1));
                else
                    chk(rx_data == prev + W'(1), "R6/R3 sequence on rising-edge path", rx_data, prev + W'(1));
                lag_now = tx_data - rx_data;
                chk(lag_now == lag0, "R7 constant lag", lag_now, lag0);
                prev = rx_data;
            end
        end
        finish_run();
    end

endmodule